// File: doc/BRIEF.md
# Bounded Block Transfer Address Sequencer

This block moves a block of 16-bit words between system memory and a serial drive channel for a storage controller. Software hands it one address, which is one below the first data word. The block first reads the word stored at that address. That word is the end bound: one past the last data word. The block then steps a current-address register upward, one word per access. It stops when the register reaches the bound and raises a one-cycle completion pulse.

There are two directions. Toward the drive, the block fetches each word from memory and shifts it out one bit per drive bit strobe. From the drive, it gathers bits into words and writes each word to memory. The memory side is a request/grant port. A request is held until it is granted, so the grant acts as the ready of that port and memory may stall it freely. The serial side is paced only by the drive's bit strobe and cannot be held back. If memory falls a whole word behind the drive, the block records lost data and stops early.

Top module: `blk_xfer_seq`

## Requirements
- R1: A `start` pulse is taken only while the block is idle with `ctl_ready` and `drv_on_cyl` both high. Any other `start` leaves `busy` low and issues no memory request, and a `start` seen while busy does not disturb the running transfer.
- R2: When a start is taken, `busy` rises, and in the next cycle a memory read (`mem_we` = 0) is pending at `fwa_m1`. The data granted for that read becomes the end bound.
- R3: Data accesses go to `fwa_m1`+1, `fwa_m1`+2, and so on upward. Each step raises the current address by exactly one, and the address is stepped before the access that uses it.
- R4: The number of data words moved is the bound minus (`fwa_m1`+1). The block reads or writes no word at or beyond the bound. `done` is raised in a cycle where `busy` and `mem_req` are already low.
- R5: Toward the drive (`to_drive` = 1), each memory word is sent most significant bit first on `sout_bit`. `sout_valid` is high while a word is being sent. A bit is used up on each cycle where `bit_tick` and `sout_valid` are both high, and the bit holds steady between strobes.
- R6: From the drive (`to_drive` = 0), `sin_bit` is sampled on each `bit_tick` once the bound has been fetched. Bits fill the word most significant bit first. The cycle after the strobe carrying a word's 16th bit, a memory write of that word is pending at the next address.
- R7: A memory request keeps `mem_req`, `mem_addr`, `mem_we` and `mem_wdata` steady until the cycle in which `mem_gnt` is high. Read data is taken in that same cycle. The only exception is an abort, which withdraws the request.
- R8: Toward the drive, if a word's last bit is used up while the next needed word is not already in the block's holding register, the transfer aborts. `done` pulses, `lost_data` goes high, and any pending request is withdrawn. A grant in that same cycle counts as too late.
- R9: From the drive, if a word completes while the previous word's write is still ungranted, and more words remain, the transfer aborts in the same way as R8. A grant in that same cycle counts as too late.
- R10: If the fetched bound equals `fwa_m1`+1, the transfer completes with no data access and with `lost_data` low.
- R11: After reset, `busy`, `done`, `mem_req`, `lost_data` and `sout_valid` are low. `lost_data` stays set until the next start is taken.
- R12: `done` is high for exactly one cycle per transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begin a transfer (pulse) |
| to_drive | input | 1 | 1: memory to drive; 0: drive to memory |
| fwa_m1 | input | 16 | Address one below the first data word; holds the bound |
| ctl_ready | input | 1 | Controller ready |
| drv_on_cyl | input | 1 | Drive positioned on cylinder |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | One-cycle completion pulse |
| lost_data | output | 1 | Last transfer aborted for memory lag |
| mem_req | output | 1 | Memory request |
| mem_we | output | 1 | 1: write, 0: read |
| mem_addr | output | 16 | Memory word address |
| mem_wdata | output | 16 | Memory write data |
| mem_gnt | input | 1 | Memory grant; completes the request |
| mem_rdata | input | 16 | Read data, valid with the grant |
| bit_tick | input | 1 | Drive bit strobe |
| sout_bit | output | 1 | Serial data toward the drive |
| sout_valid | output | 1 | `sout_bit` carries a word bit |
| sin_bit | input | 1 | Serial data from the drive |

## Verification
An off-by-one in the current address shows at the ports on the first data access, because `mem_addr` is one word away from the expected address. It also shows at the end, as one word too many or too few before `done`. A wrong bound shows the same way, as a wrong count of grants before completion. A shift register out of step corrupts the first word's bit order. Toward the drive this is visible on `sout_bit` within 16 strobes; from the drive it is visible in the `mem_wdata` presented the cycle after the 16th strobe. A wrong lag decision shows either as `lost_data` set on a clean transfer or as a stalled memory going unflagged, within one word time of the stall.

// File: rtl/blk_xfer_pkg.sv
package blk_xfer_pkg;
  typedef enum logic [1:0] {
    SEQ_IDLE  = 2'd0,
    SEQ_FETCH = 2'd1,
    SEQ_RUN   = 2'd2
  } seq_state_t;
endpackage

// File: rtl/bxs_addr_unit.sv
module bxs_addr_unit #(
  parameter int AW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [AW-1:0] load_val,
  input  logic          step,
  input  logic          lim_we,
  input  logic [AW-1:0] lim_val,
  output logic [AW-1:0] cur,
  output logic          more
);
  logic [AW-1:0] cur_q;
  logic [AW-1:0] lim_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur_q <= '0;
      lim_q <= '0;
    end else begin
      if (load)      cur_q <= load_val;
      else if (step) cur_q <= AW'(cur_q + 1'b1);
      if (lim_we)    lim_q <= lim_val;
    end
  end

  assign cur  = cur_q;
  // words remain while the next address has not reached the bound
  assign more = AW'(cur_q + 1'b1) != lim_q;

  // R3
  addr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !load) |=> (cur_q == AW'($past(cur_q) + 1'b1)));
endmodule

// File: rtl/bxs_ser_tx.sv
module bxs_ser_tx #(
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          in_valid,
  input  logic [DW-1:0] in_data,
  output logic          in_ready,
  input  logic          bit_tick,
  output logic          sout_bit,
  output logic          sout_valid,
  output logic          starved,
  output logic          idle
);
  localparam int CW = $clog2(DW);

  logic [DW-1:0] sh_q;
  logic [DW-1:0] hold_q;
  logic [CW-1:0] cnt_q;
  logic          act_q;
  logic          full_q;
  logic          last;
  logic          load_sh;

  always_comb begin
    last    = act_q && bit_tick && (cnt_q == CW'(DW-1));
    load_sh = full_q && (!act_q || last);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q   <= '0;
      hold_q <= '0;
      cnt_q  <= '0;
      act_q  <= 1'b0;
      full_q <= 1'b0;
    end else if (clr) begin
      cnt_q  <= '0;
      act_q  <= 1'b0;
      full_q <= 1'b0;
    end else begin
      if (act_q && bit_tick) begin
        sh_q  <= {sh_q[DW-2:0], 1'b0};
        cnt_q <= CW'(cnt_q + 1'b1);
      end
      if (last) begin
        act_q <= 1'b0;
        cnt_q <= '0;
      end
      if (load_sh) begin
        sh_q   <= hold_q;
        cnt_q  <= '0;
        act_q  <= 1'b1;
        full_q <= 1'b0;
      end else if (in_valid && !full_q) begin
        hold_q <= in_data;
        full_q <= 1'b1;
      end
    end
  end

  assign in_ready   = !full_q;
  assign sout_bit   = sh_q[DW-1];
  assign sout_valid = act_q;
  assign starved    = last && !full_q;
  assign idle       = !act_q && !full_q;

  // R5
  tx_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sout_valid && !bit_tick && !clr) |=> (sout_valid && $stable(sout_bit)));
endmodule

// File: rtl/bxs_ser_rx.sv
module bxs_ser_rx #(
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          en,
  input  logic          bit_tick,
  input  logic          sin_bit,
  output logic          word_done,
  output logic [DW-1:0] word
);
  localparam int CW = $clog2(DW);

  logic [DW-2:0] sh_q;
  logic [CW-1:0] cnt_q;
  logic          take;

  always_comb begin
    take      = en && bit_tick;
    word_done = take && (cnt_q == CW'(DW-1));
    word      = {sh_q, sin_bit};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q  <= '0;
      cnt_q <= '0;
    end else if (clr) begin
      cnt_q <= '0;
    end else if (take) begin
      sh_q  <= {sh_q[DW-3:0], sin_bit};
      cnt_q <= word_done ? '0 : CW'(cnt_q + 1'b1);
    end
  end
endmodule

// File: rtl/blk_xfer_seq.sv
module blk_xfer_seq
  import blk_xfer_pkg::*;
#(
  parameter int AW = 16,
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          to_drive,
  input  logic [AW-1:0] fwa_m1,
  input  logic          ctl_ready,
  input  logic          drv_on_cyl,
  output logic          busy,
  output logic          done,
  output logic          lost_data,
  output logic          mem_req,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] mem_wdata,
  input  logic          mem_gnt,
  input  logic [DW-1:0] mem_rdata,
  input  logic          bit_tick,
  output logic          sout_bit,
  output logic          sout_valid,
  input  logic          sin_bit
);
  seq_state_t    st_q;
  logic          dir_q;
  logic          req_q;
  logic          we_q;
  logic          done_q;
  logic          lost_q;
  logic [DW-1:0] wdata_q;

  logic [AW-1:0] cur;
  logic          more;
  logic          tx_ready;
  logic          tx_starved;
  logic          tx_idle;
  logic          tx_in_valid;
  logic          rx_done;
  logic [DW-1:0] rx_word;
  logic          accept;
  logic          in_run;
  logic          in_idle;
  logic          lim_we;
  logic          issue_rd;
  logic          issue_wr;
  logic          lost_evt;
  logic          fin;

  always_comb begin
    in_idle     = (st_q == SEQ_IDLE);
    in_run      = (st_q == SEQ_RUN);
    accept      = in_idle && start && ctl_ready && drv_on_cyl;
    lim_we      = (st_q == SEQ_FETCH) && mem_gnt;
    tx_in_valid = in_run && dir_q && req_q && mem_gnt;
    issue_rd    = in_run && dir_q && !req_q && more && tx_ready;
    issue_wr    = in_run && !dir_q && !req_q && more && rx_done;
    if (dir_q) lost_evt = in_run && tx_starved && (more || req_q);
    else       lost_evt = in_run && rx_done && more && req_q;
    fin = in_run && !more && !req_q && (!dir_q || tx_idle) && !lost_evt;
  end

  bxs_addr_unit #(.AW(AW)) u_addr (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (accept),
    .load_val (fwa_m1),
    .step     (issue_rd || issue_wr),
    .lim_we   (lim_we),
    .lim_val  (mem_rdata[AW-1:0]),
    .cur      (cur),
    .more     (more)
  );

  bxs_ser_tx #(.DW(DW)) u_tx (
    .clk        (clk),
    .rst_n      (rst_n),
    .clr        (in_idle),
    .in_valid   (tx_in_valid),
    .in_data    (mem_rdata),
    .in_ready   (tx_ready),
    .bit_tick   (bit_tick),
    .sout_bit   (sout_bit),
    .sout_valid (sout_valid),
    .starved    (tx_starved),
    .idle       (tx_idle)
  );

  bxs_ser_rx #(.DW(DW)) u_rx (
    .clk       (clk),
    .rst_n     (rst_n),
    .clr       (in_idle),
    .en        (in_run && !dir_q),
    .bit_tick  (bit_tick),
    .sin_bit   (sin_bit),
    .word_done (rx_done),
    .word      (rx_word)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= SEQ_IDLE;
      dir_q   <= 1'b0;
      req_q   <= 1'b0;
      we_q    <= 1'b0;
      done_q  <= 1'b0;
      lost_q  <= 1'b0;
      wdata_q <= '0;
    end else begin
      done_q <= 1'b0;
      unique case (st_q)
        SEQ_IDLE: begin
          if (accept) begin
            st_q   <= SEQ_FETCH;
            dir_q  <= to_drive;
            req_q  <= 1'b1;
            we_q   <= 1'b0;
            lost_q <= 1'b0;
          end
        end
        SEQ_FETCH: begin
          if (mem_gnt) begin
            req_q <= 1'b0;
            st_q  <= SEQ_RUN;
          end
        end
        SEQ_RUN: begin
          if (lost_evt) begin
            lost_q <= 1'b1;
            done_q <= 1'b1;
            req_q  <= 1'b0;
            st_q   <= SEQ_IDLE;
          end else if (fin) begin
            done_q <= 1'b1;
            st_q   <= SEQ_IDLE;
          end else begin
            if (req_q && mem_gnt) req_q <= 1'b0;
            if (issue_rd) begin
              req_q <= 1'b1;
              we_q  <= 1'b0;
            end
            if (issue_wr) begin
              req_q   <= 1'b1;
              we_q    <= 1'b1;
              wdata_q <= rx_word;
            end
          end
        end
        default: st_q <= SEQ_IDLE;
      endcase
    end
  end

  assign busy      = !in_idle;
  assign done      = done_q;
  assign lost_data = lost_q;
  assign mem_req   = req_q;
  assign mem_we    = we_q;
  assign mem_addr  = cur;
  assign mem_wdata = wdata_q;

  // R1
  start_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && start && !(ctl_ready && drv_on_cyl)) |=> !busy);

  // R7
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_gnt && !lost_evt) |=>
      (mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata)));

  // R12
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R4
  done_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!busy && !mem_req));

  // R8
  lost_with_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(lost_data) |-> done);
endmodule

// File: tb/sim_blk_xfer_seq.sv
module sim_blk_xfer_seq;
  localparam int DIV = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;

  logic        start = 1'b0, to_drive = 1'b0, ctl_ready = 1'b0, drv_on_cyl = 1'b0;
  logic [15:0] fwa_m1 = '0;
  logic        busy, done, lost_data, mem_req, mem_we, sout_bit, sout_valid;
  logic [15:0] mem_addr, mem_wdata;
  logic        mem_gnt = 1'b0;
  logic [15:0] mem_rdata = '0;
  logic        bit_tick = 1'b0, sin_bit = 1'b0;

  blk_xfer_seq u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .to_drive(to_drive), .fwa_m1(fwa_m1),
    .ctl_ready(ctl_ready), .drv_on_cyl(drv_on_cyl), .busy(busy), .done(done),
    .lost_data(lost_data), .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_gnt(mem_gnt), .mem_rdata(mem_rdata),
    .bit_tick(bit_tick), .sout_bit(sout_bit), .sout_valid(sout_valid), .sin_bit(sin_bit)
  );

  logic [15:0] mem [0:255];
  logic [15:0] src [0:15];
  logic [15:0] cap [0:15];
  logic [15:0] rd_log [0:15];
  logic [15:0] cap_sh, held_addr, cur_fwa;
  int cap_n, cap_b, n_rd, n_wr, grants, gnt_limit, max_lat, lat, wait_c;
  int div_c, rbit, exp_n, hand_idx;
  bit tick_on, rd_mode, fetched, hand_pend, no_hand;
  int checks = 0, fails = 0;

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // memory and drive models, all driven at the falling edge
  always @(negedge clk) begin
    if (hand_pend) begin
      hand_pend = 0;
      chk(mem_req && mem_we && mem_wdata == src[hand_idx] && mem_addr == 16'(cur_fwa + 1 + hand_idx),
          "R6 handover after 16th bit", {15'd0, mem_req, mem_wdata}, {16'd1, src[hand_idx]});
    end
    bit_tick = 1'b0;
    if (tick_on && (!rd_mode || fetched)) begin
      div_c++;
      if (div_c >= DIV) begin
        div_c = 0;
        bit_tick = 1'b1;
        if (rd_mode) begin
          sin_bit = (rbit < 256) ? src[(rbit / 16) % 16][15 - (rbit % 16)] : 1'b0;
          rbit++;
          if (rbit % 16 == 0 && rbit / 16 <= exp_n && !no_hand) begin
            hand_pend = 1;
            hand_idx = rbit / 16 - 1;
          end
        end else if (sout_valid) begin
          cap_sh = {cap_sh[14:0], sout_bit};
          cap_b++;
          if (cap_b == 16) begin
            cap_b = 0;
            if (cap_n < 16) cap[cap_n] = cap_sh;
            cap_n++;
          end
        end
      end
    end
    if (mem_gnt) mem_gnt = 1'b0;
    else if (mem_req) begin
      if (wait_c == 0) held_addr = mem_addr;
      else chk(mem_addr == held_addr, "R7 request held", {16'd0, mem_addr}, {16'd0, held_addr});
      if (wait_c >= lat && grants < gnt_limit) begin
        mem_gnt = 1'b1;
        wait_c = 0;
        grants++;
        lat = $urandom_range(max_lat, 0);
        if (mem_we) begin
          mem[mem_addr[7:0]] = mem_wdata;
          n_wr++;
        end else begin
          mem_rdata = mem[mem_addr[7:0]];
          if (n_rd < 16) rd_log[n_rd] = mem_addr;
          n_rd++;
          if (rd_mode) fetched = 1;
        end
      end else wait_c++;
    end else wait_c = 0;
  end

  task automatic run_xfer(input bit dir_w, input logic [15:0] base, input int n, input int mlat,
                          input int glim, input bit exp_lost, input bit poke, input string tag);
    int t;
    bit seen;
    cur_fwa = base; exp_n = n; rd_mode = !dir_w; fetched = 0; rbit = 0; div_c = 0;
    cap_n = 0; cap_b = 0; n_rd = 0; n_wr = 0; grants = 0; gnt_limit = glim;
    max_lat = mlat; lat = $urandom_range(mlat, 0); wait_c = 0; no_hand = exp_lost; hand_pend = 0;
    for (int i = 0; i < 16; i++) src[i] = 16'($urandom);
    mem[base[7:0]] = 16'(base + 1 + n);
    for (int i = 0; i < n + 1; i++) mem[8'(base + 1 + i)] = dir_w ? src[i] : 16'hDEAD;
    tick_on = 1;
    @(negedge clk); to_drive = dir_w; fwa_m1 = base; start = 1'b1;
    @(negedge clk); start = 1'b0;
    chk(busy && !lost_data, {tag, " R11 busy set, lost cleared"}, {30'd0, busy, lost_data}, 32'h2);
    chk(mem_req && !mem_we && mem_addr == base, {tag, " R2 bound fetch"}, {16'd0, mem_addr}, {16'd0, base});
    if (poke) begin
      repeat (20) @(negedge clk);
      to_drive = !dir_w; fwa_m1 = base + 16'd40; start = 1'b1;
      @(negedge clk); start = 1'b0;
    end
    t = 0; seen = 0;
    while (!seen && t < 4000) begin
      @(negedge clk);
      t++;
      if (done) seen = 1;
    end
    chk(seen, {tag, " R4 done seen"}, {31'd0, seen}, 32'd1);
    chk(!busy && !mem_req, {tag, " R4 idle at done"}, {30'd0, busy, mem_req}, 32'd0);
    chk(lost_data == exp_lost, {tag, dir_w ? " R8 lost flag" : " R9 lost flag"},
        {31'd0, lost_data}, {31'd0, exp_lost});
    @(negedge clk);
    chk(!done, {tag, " R12 single-cycle done"}, {31'd0, done}, 32'd0);
    tick_on = 0;
    if (!exp_lost) begin
      if (dir_w) begin
        chk(cap_n == n, {tag, " R4 words sent"}, 32'(cap_n), 32'(n));
        for (int i = 0; i < n; i++)
          chk(cap[i] == src[i], {tag, " R5 serial word"}, {16'd0, cap[i]}, {16'd0, src[i]});
        chk(n_rd == n + 1, {tag, " R4 read count"}, 32'(n_rd), 32'(n + 1));
        for (int i = 0; i < n + 1 && i < 16; i++)
          chk(rd_log[i] == 16'(base + i), {tag, " R3 read address"}, {16'd0, rd_log[i]}, 32'(base + i));
      end else begin
        chk(n_wr == n, {tag, " R4 write count"}, 32'(n_wr), 32'(n));
        for (int i = 0; i < n; i++)
          chk(mem[8'(base + 1 + i)] == src[i], {tag, " R6 stored word"},
              {16'd0, mem[8'(base + 1 + i)]}, {16'd0, src[i]});
        chk(mem[8'(base + 1 + n)] == 16'hDEAD, {tag, " R4 no overrun"},
            {16'd0, mem[8'(base + 1 + n)]}, 32'hDEAD);
      end
    end
    repeat (3) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: run did not finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd1729));
    for (int i = 0; i < 256; i++) mem[i] = '0;
    tick_on = 0; rd_mode = 0; hand_pend = 0; gnt_limit = 0; max_lat = 0; lat = 0; wait_c = 0;
    repeat (3) @(negedge clk);
    chk(!busy && !done && !mem_req && !lost_data && !sout_valid, "R11 reset state",
        {27'd0, busy, done, mem_req, lost_data, sout_valid}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    ctl_ready = 1'b1; drv_on_cyl = 1'b0; start = 1'b1;
    @(negedge clk); start = 1'b0;
    repeat (4) @(negedge clk);
    chk(!busy && !mem_req, "R1 start ignored off cylinder", {30'd0, busy, mem_req}, 32'd0);
    ctl_ready = 1'b0; drv_on_cyl = 1'b1; start = 1'b1;
    @(negedge clk); start = 1'b0;
    repeat (4) @(negedge clk);
    chk(!busy && !mem_req, "R1 start ignored not ready", {30'd0, busy, mem_req}, 32'd0);
    ctl_ready = 1'b1;

    run_xfer(1'b1, 16'h0020, 4, 2, 99, 1'b0, 1'b0, "dir write");
    run_xfer(1'b0, 16'h0040, 5, 3, 99, 1'b0, 1'b0, "dir read");
    run_xfer(1'b1, 16'h0060, 0, 1, 99, 1'b0, 1'b0, "R10 empty write");
    run_xfer(1'b0, 16'h0070, 0, 1, 99, 1'b0, 1'b0, "R10 empty read");
    run_xfer(1'b1, 16'h0080, 3, 1, 99, 1'b0, 1'b1, "R1 start while busy");
    run_xfer(1'b1, 16'h0090, 3, 0, 2, 1'b1, 1'b0, "R8 stalled memory");
    run_xfer(1'b0, 16'h00A0, 3, 0, 1, 1'b1, 1'b0, "R9 stalled memory");
    run_xfer(1'b0, 16'h00B0, 1, 0, 99, 1'b0, 1'b0, "R11 after abort");
    for (int k = 0; k < 8; k++)
      run_xfer(1'($urandom_range(1, 0)), 16'($urandom_range(200, 0)), $urandom_range(6, 1),
               $urandom_range(3, 0), 99, 1'b0, 1'b0, "random");

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule